// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block models the command decoder and status logic of a byte-wide flash device. A host issues bus writes of command bytes, each with an address, and the block decides what later reads return: array contents, identifier codes, or a status byte. One-cycle commands change the read source or clear errors. Two-cycle sequences (a setup byte followed by a confirm or data byte) launch a simulated program, erase or lock engine. The busy time of each operation is a parameter in clock cycles.

An operation in progress can be suspended and then resumed. While it is suspended the host may read the array. Errors are reported through sticky status flags that only an explicit clear command removes. A supply-good input models the high-voltage rail, and it is sampled when an operation launches. The array is a small behavioural RAM split into equal blocks, and it comes out of reset fully erased.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write of FFH makes reads return array bytes, 90H makes them return identifier codes, and 70H makes them return the status byte. The read data appears on `rdata` one cycle after `rd_en`.
- R2: The identifier space repeats in every block and is decoded from the in-block offset. Offset 0 returns MFR_CODE, offset 1 returns DEV_CODE, offset 2 returns the lock bit of the addressed block in bit 0, offset 3 returns the master lock in bit 0, and every other offset returns 00H.
- R3: The status byte is laid out as follows. Bit 7 is ready. Bit 6 is erase suspended. Bit 5 is erase error. Bit 4 is program error. Bit 3 is supply error. Bit 2 is program suspended. Bit 1 is lock error. Bit 0 is always 0. Writing 20H and then D0H at an address starts an erase: bit 7 reads 0 for ERASE_CYC cycles, after which every byte of that block reads FFH.
- R4: Writing 40H or 10H and then a data byte at an address starts a byte program. After PROG_CYC cycles the byte holds its old value AND the data.
- R5: Once the second byte of any two-cycle sequence is written, reads return status until a new read-mode command is written.
- R6: While an operation runs and is not suspended, FFH is ignored and reads keep returning status, but 70H is still accepted.
- R7: B0H during an erase or program suspends it. Bit 7 then reads 1, bit 6 (erase) or bit 2 (program) reads 1, and the remaining busy time is frozen. D0H resumes the operation, clears the suspend bit, and the operation completes after its remaining cycles.
- R8: A second byte that the sequence does not accept (for example 20H followed by 55H) sets bits 5 and 4, leaves the array unchanged, and leaves reads on status.
- R9: If `vpp_ok` is 0 when an operation would launch, bit 3 is set, no operation starts, and the array is unchanged.
- R10: Bits 5, 4, 3 and 1 stay set until a 50H command clears them. A 50H written while an operation is suspended (or running) is ignored.
- R11: 60H followed by 01H sets the lock of the addressed block, 60H then D0H clears all block locks, and 60H then F1H sets the master lock. A program or erase aimed at a locked block is rejected with bit 1 plus bit 4 (program) or bit 5 (erase). While the master lock is set, a block-lock set is rejected with bits 1 and 4, and a block-lock clear is rejected with bits 1 and 5.
- R12: Reset selects array reads, sets the status to 80H, clears all locks, erases the array and aborts any running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command or data write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Command or data byte |
| vpp_ok | input | 1 | High-voltage supply present |
| rdata | output | 8 | Registered read data |

## Verification
An internal mode register that is stuck or wrong shows up on the very next read. The host expects a status byte and gets array data, or the reverse, and the two differ in known bit patterns. A busy counter that is lost or that keeps running while suspended shows as a ready bit that rises too early or too late, and as the target block holding its old contents or reading FFH at the wrong point. Each of these faults becomes visible within one read after the command, or within one busy period. Sticky flags that are cleared or set wrongly appear in the next status read.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
   typedef enum logic [1:0] {RD_ARRAY, RD_ID, RD_STAT} rd_mode_e;
   typedef enum logic [1:0] {PEND_NONE, PEND_ERASE, PEND_PROG, PEND_LOCK} pend_e;
   typedef enum logic [2:0] {OP_ERASE, OP_PROG, OP_SETBLK, OP_SETMST, OP_CLRBLK} op_e;

   localparam logic [7:0] C_READ    = 8'hFF;
   localparam logic [7:0] C_IDENT   = 8'h90;
   localparam logic [7:0] C_STATUS  = 8'h70;
   localparam logic [7:0] C_CLEAR   = 8'h50;
   localparam logic [7:0] C_ERASE   = 8'h20;
   localparam logic [7:0] C_PROG_A  = 8'h40;
   localparam logic [7:0] C_PROG_B  = 8'h10;
   localparam logic [7:0] C_LOCK    = 8'h60;
   localparam logic [7:0] C_SUSPEND = 8'hB0;
   localparam logic [7:0] C_CONFIRM = 8'hD0;
   localparam logic [7:0] C_SETBLK  = 8'h01;
   localparam logic [7:0] C_SETMST  = 8'hF1;
endpackage

// File: rtl/fcmd_array.sv
module fcmd_array #(
   parameter int ADDR_W = 8,
   parameter int BLK_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   output logic [7:0]              rd_byte_o,
   input  logic                    prg_en_i,
   input  logic [ADDR_W-1:0]       prg_addr_i,
   input  logic [7:0]              prg_data_i,
   input  logic                    ers_en_i,
   input  logic [ADDR_W-BLK_W-1:0] ers_blk_i
);
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int BLK_BYTES = 1 << BLK_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (ers_en_i) begin
         for (int i = 0; i < BLK_BYTES; i++) mem[{ers_blk_i, BLK_W'(i)}] <= 8'hFF;
      end else if (prg_en_i) begin
         mem[prg_addr_i] <= mem[prg_addr_i] & prg_data_i;
      end
   end

   assign rd_byte_o = mem[rd_addr_i];

   // R3 / R4: the controller never requests erase and program in one cycle
   a_r3_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prg_en_i, ers_en_i}));
endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] dur_i,
   input  logic             susp_i,
   input  logic             resume_i,
   output logic             busy_o,
   output logic             susp_o,
   output logic             done_o
);
   logic             active_q;
   logic             susp_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         susp_q   <= 1'b0;
         cnt_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         susp_q   <= 1'b0;
         cnt_q    <= dur_i;
      end else if (active_q) begin
         if (susp_q) begin
            if (resume_i) susp_q <= 1'b0;
         end else if (susp_i) begin
            susp_q <= 1'b1;
         end else if (cnt_q == CNT_W'(1)) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign busy_o = active_q;
   assign susp_o = susp_q;
   assign done_o = active_q && !susp_q && !susp_i && (cnt_q == CNT_W'(1));

   // R7: remaining time is frozen while suspended
   a_r7_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && susp_q && !resume_i && !start_i) |=> ($stable(cnt_q) && susp_q));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcmd_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter int         BLK_W     = 4,
   parameter int         ERASE_CYC = 20,
   parameter int         PROG_CYC  = 6,
   parameter int         LOCK_CYC  = 4,
   parameter logic [7:0] MFR_CODE  = 8'h5A,
   parameter logic [7:0] DEV_CODE  = 8'hC3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              vpp_ok,
   output logic [7:0]        rdata
);
   localparam int NBLK_W  = ADDR_W - BLK_W;
   localparam int NBLK    = 1 << NBLK_W;
   localparam int MAX_CYC = (ERASE_CYC > PROG_CYC)
                            ? ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC)
                            : ((PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (BLK_W < 2 || NBLK_W < 1) begin : g_bad_geom
         $error("flash_cmd_ctrl: block geometry out of range");
      end
      if (ERASE_CYC < 1 || PROG_CYC < 1 || LOCK_CYC < 1) begin : g_bad_cyc
         $error("flash_cmd_ctrl: busy durations must be at least one cycle");
      end
   endgenerate

   rd_mode_e          mode_q;
   pend_e             pend_q;
   op_e               op_q, new_op;
   logic [ADDR_W-1:0] op_addr_q;
   logic [7:0]        op_data_q;
   logic              e_ers_q, e_prg_q, e_vpp_q, e_lck_q;
   logic              mst_q;
   logic [NBLK-1:0]   blk_lock_q;
   logic [7:0]        rdata_q;

   logic              busy, susp, done;
   logic              second, seq_ok, blocked, launch, susp_req, resume_req;
   logic [CNT_W-1:0]  dur;
   logic [7:0]        status, id_byte, arr_byte;
   logic [NBLK_W-1:0] blk;

   assign blk    = addr[ADDR_W-1:BLK_W];
   assign second = wr_en && (pend_q != PEND_NONE);

   always_comb begin
      seq_ok = 1'b0;
      new_op = OP_ERASE;
      unique case (pend_q)
         PEND_ERASE: seq_ok = (wdata == C_CONFIRM);
         PEND_PROG: begin
            seq_ok = 1'b1;
            new_op = OP_PROG;
         end
         PEND_LOCK: begin
            if (wdata == C_SETBLK) begin
               seq_ok = 1'b1; new_op = OP_SETBLK;
            end else if (wdata == C_SETMST) begin
               seq_ok = 1'b1; new_op = OP_SETMST;
            end else if (wdata == C_CONFIRM) begin
               seq_ok = 1'b1; new_op = OP_CLRBLK;
            end
         end
         default: ;
      endcase
      unique case (new_op)
         OP_ERASE: dur = CNT_W'(ERASE_CYC);
         OP_PROG:  dur = CNT_W'(PROG_CYC);
         default:  dur = CNT_W'(LOCK_CYC);
      endcase
   end

   assign blocked    = (((new_op == OP_ERASE) || (new_op == OP_PROG)) && blk_lock_q[blk])
                    || (((new_op == OP_SETBLK) || (new_op == OP_CLRBLK)) && mst_q);
   assign launch     = second && seq_ok && vpp_ok && !blocked;
   assign susp_req   = wr_en && (pend_q == PEND_NONE) && busy && !susp
                    && (wdata == C_SUSPEND) && ((op_q == OP_ERASE) || (op_q == OP_PROG));
   assign resume_req = wr_en && (pend_q == PEND_NONE) && susp && (wdata == C_CONFIRM);

   fcmd_engine #(.CNT_W(CNT_W)) engine_i (
      .clk(clk), .rst_n(rst_n), .start_i(launch), .dur_i(dur),
      .susp_i(susp_req), .resume_i(resume_req),
      .busy_o(busy), .susp_o(susp), .done_o(done)
   );

   fcmd_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) array_i (
      .clk(clk), .rst_n(rst_n), .rd_addr_i(addr), .rd_byte_o(arr_byte),
      .prg_en_i(done && (op_q == OP_PROG)), .prg_addr_i(op_addr_q), .prg_data_i(op_data_q),
      .ers_en_i(done && (op_q == OP_ERASE)), .ers_blk_i(op_addr_q[ADDR_W-1:BLK_W])
   );

   generate
      for (genvar g = 0; g < NBLK; g++) begin : g_lock
         always_ff @(posedge clk) begin
            if (!rst_n)
               blk_lock_q[g] <= 1'b0;
            else if (done && (op_q == OP_CLRBLK))
               blk_lock_q[g] <= 1'b0;
            else if (done && (op_q == OP_SETBLK) && (op_addr_q[ADDR_W-1:BLK_W] == NBLK_W'(g)))
               blk_lock_q[g] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= RD_ARRAY;
         pend_q    <= PEND_NONE;
         op_q      <= OP_ERASE;
         op_addr_q <= '0;
         op_data_q <= '0;
         {e_ers_q, e_prg_q, e_vpp_q, e_lck_q} <= '0;
         mst_q     <= 1'b0;
      end else begin
         if (done && (op_q == OP_SETMST)) mst_q <= 1'b1;
         if (second) begin
            pend_q <= PEND_NONE;
            mode_q <= RD_STAT;
            if (launch) begin
               op_q      <= new_op;
               op_addr_q <= addr;
               op_data_q <= wdata;
            end else if (!seq_ok) begin
               e_ers_q <= 1'b1;
               e_prg_q <= 1'b1;
            end else if (!vpp_ok) begin
               e_vpp_q <= 1'b1;
            end else begin
               e_lck_q <= 1'b1;
               if ((new_op == OP_ERASE) || (new_op == OP_CLRBLK)) e_ers_q <= 1'b1;
               else                                               e_prg_q <= 1'b1;
            end
         end else if (wr_en && busy && !susp) begin
            if ((wdata == C_STATUS) || susp_req) mode_q <= RD_STAT;
         end else if (wr_en && susp) begin
            unique case (wdata)
               C_READ:              mode_q <= RD_ARRAY;
               C_IDENT:             mode_q <= RD_ID;
               C_STATUS, C_CONFIRM: mode_q <= RD_STAT;
               default: ;
            endcase
         end else if (wr_en) begin
            unique case (wdata)
               C_READ:             mode_q <= RD_ARRAY;
               C_IDENT:            mode_q <= RD_ID;
               C_STATUS:           mode_q <= RD_STAT;
               C_CLEAR:            {e_ers_q, e_prg_q, e_vpp_q, e_lck_q} <= '0;
               C_ERASE: begin
                  pend_q <= PEND_ERASE; mode_q <= RD_STAT;
               end
               C_PROG_A, C_PROG_B: begin
                  pend_q <= PEND_PROG; mode_q <= RD_STAT;
               end
               C_LOCK: begin
                  pend_q <= PEND_LOCK; mode_q <= RD_STAT;
               end
               default: ;
            endcase
         end
      end
   end

   assign status = {(!busy || susp), (susp && (op_q == OP_ERASE)), e_ers_q, e_prg_q,
                    e_vpp_q, (susp && (op_q == OP_PROG)), e_lck_q, 1'b0};

   always_comb begin
      unique case (addr[BLK_W-1:0])
         BLK_W'(0): id_byte = MFR_CODE;
         BLK_W'(1): id_byte = DEV_CODE;
         BLK_W'(2): id_byte = {7'b0, blk_lock_q[blk]};
         BLK_W'(3): id_byte = {7'b0, mst_q};
         default:   id_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= 8'h00;
      else if (rd_en)
         unique case (mode_q)
            RD_ARRAY: rdata_q <= arr_byte;
            RD_ID:    rdata_q <= id_byte;
            default:  rdata_q <= status;
         endcase
   end

   assign rdata = rdata_q;

   // R6: a running, unsuspended operation never leaves array reads selected
   a_r6_no_array_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !susp) |-> (mode_q != RD_ARRAY));

   // R5: any completed two-cycle sequence selects status reads
   a_r5_status_after_seq: assert property (@(posedge clk) disable iff (!rst_n)
      second |=> (mode_q == RD_STAT));

   // R10: error flags only fall on an accepted clear command
   a_r10_sticky_errors: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (pend_q == PEND_NONE) && !busy && (wdata == C_CLEAR))
      |=> (($past({e_ers_q, e_prg_q, e_vpp_q, e_lck_q}) & ~{e_ers_q, e_prg_q, e_vpp_q, e_lck_q}) == 4'b0));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
   localparam int ECYC = 20;
   localparam int PCYC = 6;
   localparam int LCYC = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       vpp_ok = 1'b1;
   logic [7:0] rdata;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   flash_cmd_ctrl #(.ADDR_W(8), .BLK_W(4), .ERASE_CYC(ECYC), .PROG_CYC(PCYC),
                    .LOCK_CYC(LCYC), .MFR_CODE(8'h5A), .DEV_CODE(8'hC3)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .vpp_ok(vpp_ok), .rdata(rdata)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         fails  = fails + 1;
         checks = checks + 1;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      rd(8'h00, v); chk("R12 array mode after reset", v, 8'hFF);
      wr(8'h00, 8'h70);
      rd(8'h00, v); chk("R12 status after reset", v, 8'h80);
   endtask

   task automatic t_program();
      logic [7:0] v;
      wr(8'h40, 8'h40); wr(8'h40, 8'h3C);
      rd(8'h40, v); chk("R5 status while programming", v, 8'h00);
      idle(PCYC + 2);
      rd(8'h40, v); chk("R4 ready after program", v, 8'h80);
      wr(8'h00, 8'hFF);
      rd(8'h40, v); chk("R4 programmed byte", v, 8'h3C);
      wr(8'h40, 8'h10); wr(8'h40, 8'hF0);
      idle(PCYC + 2);
      rd(8'h41, v); chk("R5 status stays after completion", v, 8'h80);
      wr(8'h00, 8'hFF);
      rd(8'h40, v); chk("R4 program ANDs bits", v, 8'h30);
   endtask

   task automatic t_ident();
      logic [7:0] v;
      wr(8'h00, 8'h90);
      rd(8'h00, v); chk("R2 manufacturer code", v, 8'h5A);
      rd(8'h71, v); chk("R2 device code", v, 8'hC3);
      rd(8'h12, v); chk("R2 block lock clear", v, 8'h00);
      rd(8'h13, v); chk("R2 master lock clear", v, 8'h00);
      rd(8'h17, v); chk("R2 other offset", v, 8'h00);
      wr(8'h00, 8'h70);
      rd(8'h00, v); chk("R1 status select", v, 8'h80);
      wr(8'h00, 8'hFF);
      rd(8'h40, v); chk("R1 array select", v, 8'h30);
   endtask

   task automatic t_erase_busy();
      logic [7:0] v;
      wr(8'h15, 8'h40); wr(8'h15, 8'h0F);
      idle(PCYC + 2);
      wr(8'h10, 8'h20); wr(8'h10, 8'hD0);
      rd(8'h15, v); chk("R3 not ready during erase", v, 8'h00);
      wr(8'h00, 8'hFF);
      rd(8'h15, v); chk("R6 read-array ignored while busy", v, 8'h00);
      wr(8'h00, 8'h70);
      idle(ECYC);
      rd(8'h15, v); chk("R3 ready after erase", v, 8'h80);
      wr(8'h00, 8'hFF);
      rd(8'h15, v); chk("R3 erased byte", v, 8'hFF);
      rd(8'h40, v); chk("R3 other block untouched", v, 8'h30);
   endtask

   task automatic t_suspend();
      logic [7:0] v;
      wr(8'h25, 8'h40); wr(8'h25, 8'h11);
      idle(PCYC + 2);
      wr(8'h20, 8'h20); wr(8'h20, 8'hD0);
      idle(3);
      wr(8'h00, 8'hB0);
      rd(8'h00, v); chk("R7 erase suspended status", v, 8'hC0);
      wr(8'h00, 8'hFF);
      rd(8'h25, v); chk("R7 array readable while suspended", v, 8'h11);
      idle(3 * ECYC);
      wr(8'h00, 8'hD0);
      rd(8'h00, v); chk("R7 still busy after resume", v, 8'h00);
      idle(ECYC);
      rd(8'h00, v); chk("R7 resumed erase completes", v, 8'h80);
      wr(8'h00, 8'hFF);
      rd(8'h25, v); chk("R7 block erased after resume", v, 8'hFF);
      wr(8'h30, 8'h40); wr(8'h30, 8'h00);
      wr(8'h00, 8'hB0);
      rd(8'h00, v); chk("R7 program suspended status", v, 8'h84);
      wr(8'h00, 8'hD0);
      idle(PCYC + 2);
      rd(8'h00, v); chk("R7 program resumes and ends", v, 8'h80);
   endtask

   task automatic t_errors();
      logic [7:0] v;
      wr(8'h40, 8'h20); wr(8'h40, 8'h55);
      rd(8'h40, v); chk("R8 bad confirm flags", v, 8'hB0);
      wr(8'h00, 8'hFF);
      rd(8'h40, v); chk("R8 array unchanged", v, 8'h30);
      wr(8'h50, 8'h20); wr(8'h50, 8'hD0);
      wr(8'h00, 8'hB0);
      wr(8'h00, 8'h50);
      rd(8'h00, v); chk("R10 clear ignored while suspended", v, 8'hF0);
      wr(8'h00, 8'hD0);
      idle(ECYC + 2);
      rd(8'h00, v); chk("R10 errors sticky", v, 8'hB0);
      wr(8'h00, 8'h50);
      rd(8'h00, v); chk("R10 clear in idle", v, 8'h80);
   endtask

   task automatic t_vpp();
      logic [7:0] v;
      vpp_ok = 1'b0;
      wr(8'h60, 8'h40); wr(8'h60, 8'h00);
      rd(8'h00, v); chk("R9 supply error", v, 8'h88);
      vpp_ok = 1'b1;
      wr(8'h00, 8'hFF);
      rd(8'h60, v); chk("R9 array unchanged", v, 8'hFF);
      wr(8'h00, 8'h50);
   endtask

   task automatic t_locks();
      logic [7:0] v;
      wr(8'h20, 8'h60); wr(8'h20, 8'h01);
      idle(LCYC + 2);
      wr(8'h00, 8'h90);
      rd(8'h22, v); chk("R11 block lock set", v, 8'h01);
      wr(8'h25, 8'h40); wr(8'h25, 8'h00);
      rd(8'h00, v); chk("R11 program to locked block", v, 8'h92);
      wr(8'h00, 8'hFF);
      rd(8'h25, v); chk("R11 locked byte unchanged", v, 8'hFF);
      wr(8'h00, 8'h50);
      wr(8'h20, 8'h60); wr(8'h20, 8'hD0);
      idle(LCYC + 2);
      wr(8'h00, 8'h90);
      rd(8'h22, v); chk("R11 locks cleared", v, 8'h00);
      wr(8'h00, 8'h60); wr(8'h00, 8'hF1);
      idle(LCYC + 2);
      wr(8'h00, 8'h90);
      rd(8'h03, v); chk("R11 master lock set", v, 8'h01);
      wr(8'h30, 8'h60); wr(8'h30, 8'h01);
      rd(8'h00, v); chk("R11 block lock under master", v, 8'h92);
      wr(8'h00, 8'h90);
      rd(8'h32, v); chk("R11 block stays unlocked", v, 8'h00);
      wr(8'h00, 8'h50);
   endtask

   task automatic t_reset_abort();
      logic [7:0] v;
      wr(8'h00, 8'h20); wr(8'h00, 8'hD0);
      idle(3);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      rd(8'h03, v); chk("R12 array mode after abort", v, 8'hFF);
      wr(8'h00, 8'h70);
      rd(8'h00, v); chk("R12 ready after abort", v, 8'h80);
      idle(ECYC + 2);
      rd(8'h00, v); chk("R12 no late completion", v, 8'h80);
      wr(8'h00, 8'h90);
      rd(8'h03, v); chk("R12 master lock cleared", v, 8'h00);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset_state();
      t_program();
      t_ident();
      t_erase_busy();
      t_suspend();
      t_errors();
      t_vpp();
      t_locks();
      t_reset_abort();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule